// File: doc/BRIEF.md
# Banked GPIO Port with Edge Interrupts

This block is the pin-side core of a GPIO expander. It serves up to 24 pins, grouped into 8-bit banks, through a byte-wide register bus with an address, write data, a write enable and a combinational read-data return. Each pin has an output latch, a direction bit, separate rising and falling edge enables and an interrupt enable. The block resynchronizes the pad inputs, finds the selected edges, records them per pin and drives one active-high interrupt line.

Software drives outputs through a write-one-to-set and a write-one-to-clear register, or through one combined output register in a parameter-selected variant. It services an interrupt by reading the status bytes as a burst and writing the same bytes back to clear them. Configuration registers count down from their base address by bank. The two status families count up from their base starting at the highest bank.

Top module: `gpx_bank_port`

## Requirements
- R1: After reset every output latch, direction bit, edge enable, interrupt enable, interrupt status bit and edge-detect bit is 0, so pad_oe, pad_out and irq are all 0.
- R2: The input-state, set, clear, direction, rising-enable, falling-enable and interrupt-enable families place bank k at their base address minus k. The defaults are input 0x12, set 0x15, clear 0x18, direction 0x1B, rising 0x1E, falling 0x21 and interrupt enable 0x24. Pin n is bit n%8 of bank n/8.
- R3: With SPLIT_OUT=1, a 1 written to the set register drives that pin's output latch high and a 1 written to the clear register drives it low. Zero bits leave the latch unchanged, and both addresses read back the latch.
- R4: With SPLIT_OUT=0, a write to the set address loads the output latch: 1 bits drive high and 0 bits drive low. Writes to the clear address have no effect.
- R5: pad_oe of a pin equals its direction bit, where 1 means output and 0 means input. pad_out equals the output latch.
- R6: The input-state register returns each pad value after a two-flop synchronizer. A pad change made before clock edge k is readable after edge k+1.
- R7: A pin's edge-detect bit is set when its synchronized value rises with the rising enable set, or falls with the falling enable set. Both edges can be enabled at once. It is set one edge after the synchronized change and is independent of direction.
- R8: A pin's interrupt status bit is set by the same selected edges, but only while the pin's direction bit is 0.
- R9: The interrupt-status and edge-detect families place bank NB-1-i at base plus i, where NB is the number of banks. The defaults are status 0x30 and edge-detect 0x34.
- R10: Writing a byte to a status or edge-detect address clears exactly the bits written as 1. All other bits keep their value.
- R11: irq is high exactly when some pin has both its interrupt status bit and its interrupt enable bit set.
- R12: If a selected edge and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R13: Bits of pins at or above NUM_PINS read 0 and cannot be set. Unmapped addresses, and the clear address in the combined variant, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Output latch values |
| pad_oe | output | NUM_PINS | Output enables (direction bits) |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach from the ports is a write-one-to-clear that lands in exactly the cycle in which a new edge sets the same status bit. Only a clear that lands in that cycle shows whether the edge or the clear wins. The bench counts the synchronizer and edge stages from a pad change made at a falling clock edge. It then places the clearing write so that it is sampled at the second rising edge after the pad is first captured. It repeats this for the edge-detect register, and it also clears a bit with the pads quiet to show that the clear works on its own. Random register writes and pad changes run on a full-width instance, and a 12-pin instance in the combined-output variant covers the partial bank and the two-bank burst order.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BANK_W   = 8;
    localparam int MAX_PINS = 24;

    typedef logic [BANK_W-1:0] byte_t;

    // Per-bank write strobes produced by the address decoder
    typedef struct packed {
        logic out_set;
        logic out_clr;
        logic out_load;
        logic dir;
        logic rise;
        logic fall;
        logic ien;
        logic stat_clr;
        logic edg_clr;
    } bank_wr_t;

    // Per-bank register view shared by read mux and interrupt merge
    typedef struct packed {
        byte_t pin;
        byte_t out;
        byte_t dir;
        byte_t rise;
        byte_t fall;
        byte_t ien;
        byte_t stat;
        byte_t edg;
    } bank_view_t;

    function automatic int num_banks(input int pins);
        return (pins + BANK_W - 1) / BANK_W;
    endfunction

    // Bits of a bank that correspond to existing pins
    function automatic byte_t valid_mask(input int pins, input int bank);
        byte_t m;
        for (int b = 0; b < BANK_W; b++) begin
            m[b] = ((bank * BANK_W + b) < pins);
        end
        return m;
    endfunction

    // Address of bank k in a family that counts down from its base
    function automatic int down_addr(input int base, input int bank);
        return base - bank;
    endfunction

    // Address of bank k in a family read as a burst from the top bank
    function automatic int up_addr(input int base, input int banks, input int bank);
        return base + (banks - 1 - bank);
    endfunction

endpackage

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rose,
    output logic [WIDTH-1:0] fell
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rose  = sync_q & ~prev_q;
    assign fell  = ~sync_q & prev_q;

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter byte_t VALID = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_wr_t   wr,
    input  byte_t      wdata,
    input  byte_t      level,
    input  byte_t      rose,
    input  byte_t      fell,
    output bank_view_t view,
    output byte_t      evt
);

    byte_t out_q, dir_q, rise_q, fall_q, ien_q, stat_q, edg_q;
    byte_t wmask;
    byte_t stat_evt;
    byte_t stat_wipe, edg_wipe;

    assign wmask     = wdata & VALID;
    assign evt       = ((rose & rise_q) | (fell & fall_q)) & VALID;
    assign stat_evt  = evt & ~dir_q;
    assign stat_wipe = wr.stat_clr ? wdata : '0;
    assign edg_wipe  = wr.edg_clr  ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            edg_q  <= '0;
        end else begin
            if (wr.out_set) begin
                out_q <= out_q | wmask;
            end else if (wr.out_clr) begin
                out_q <= out_q & ~wmask;
            end else if (wr.out_load) begin
                out_q <= wmask;
            end
            if (wr.dir)  dir_q  <= wmask;
            if (wr.rise) rise_q <= wmask;
            if (wr.fall) fall_q <= wmask;
            if (wr.ien)  ien_q  <= wmask;
            // a fresh event outranks a same-cycle clear
            stat_q <= (stat_q & ~stat_wipe) | stat_evt;
            edg_q  <= (edg_q  & ~edg_wipe)  | evt;
        end
    end

    always_comb begin
        view.pin  = level & VALID;
        view.out  = out_q;
        view.dir  = dir_q;
        view.rise = rise_q;
        view.fall = fall_q;
        view.ien  = ien_q;
        view.stat = stat_q;
        view.edg  = edg_q;
    end

endmodule

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int ADDR_W    = 8,
    parameter bit SPLIT_OUT = 1'b1,
    parameter int PIN_BASE  = 'h12,
    parameter int SET_BASE  = 'h15,
    parameter int CLR_BASE  = 'h18,
    parameter int DIR_BASE  = 'h1B,
    parameter int RISE_BASE = 'h1E,
    parameter int FALL_BASE = 'h21,
    parameter int IEN_BASE  = 'h24,
    parameter int STAT_BASE = 'h30,
    parameter int EDGE_BASE = 'h34,
    localparam int NB       = num_banks(NUM_PINS)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  bank_view_t        views [NB],
    output bank_wr_t          wr    [NB],
    output byte_t             rdata
);

    int a;
    assign a = int'(bus_addr);

    for (genvar k = 0; k < NB; k++) begin : g_wr
        localparam int A_SET  = down_addr(SET_BASE, k);
        localparam int A_CLR  = down_addr(CLR_BASE, k);
        localparam int A_DIR  = down_addr(DIR_BASE, k);
        localparam int A_RISE = down_addr(RISE_BASE, k);
        localparam int A_FALL = down_addr(FALL_BASE, k);
        localparam int A_IEN  = down_addr(IEN_BASE, k);
        localparam int A_STAT = up_addr(STAT_BASE, NB, k);
        localparam int A_EDGE = up_addr(EDGE_BASE, NB, k);

        if (SPLIT_OUT) begin : g_split
            assign wr[k].out_set  = bus_we && (a == A_SET);
            assign wr[k].out_clr  = bus_we && (a == A_CLR);
            assign wr[k].out_load = 1'b0;
        end else begin : g_comb
            assign wr[k].out_set  = 1'b0;
            assign wr[k].out_clr  = 1'b0;
            assign wr[k].out_load = bus_we && (a == A_SET);
        end
        assign wr[k].dir      = bus_we && (a == A_DIR);
        assign wr[k].rise     = bus_we && (a == A_RISE);
        assign wr[k].fall     = bus_we && (a == A_FALL);
        assign wr[k].ien      = bus_we && (a == A_IEN);
        assign wr[k].stat_clr = bus_we && (a == A_STAT);
        assign wr[k].edg_clr  = bus_we && (a == A_EDGE);
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NB; k++) begin
            if (a == down_addr(PIN_BASE, k))     rdata = views[k].pin;
            if (a == down_addr(SET_BASE, k))     rdata = views[k].out;
            if (SPLIT_OUT && (a == down_addr(CLR_BASE, k))) rdata = views[k].out;
            if (a == down_addr(DIR_BASE, k))     rdata = views[k].dir;
            if (a == down_addr(RISE_BASE, k))    rdata = views[k].rise;
            if (a == down_addr(FALL_BASE, k))    rdata = views[k].fall;
            if (a == down_addr(IEN_BASE, k))     rdata = views[k].ien;
            if (a == up_addr(STAT_BASE, NB, k))  rdata = views[k].stat;
            if (a == up_addr(EDGE_BASE, NB, k))  rdata = views[k].edg;
        end
    end

endmodule

// File: rtl/gpx_irq_merge.sv
module gpx_irq_merge
    import gpx_pkg::*;
#(
    parameter int NB = 3
) (
    input  bank_view_t views [NB],
    output logic       irq
);

    logic [NB-1:0] bank_hit;

    for (genvar k = 0; k < NB; k++) begin : g_hit
        assign bank_hit[k] = |(views[k].stat & views[k].ien);
    end

    assign irq = |bank_hit;

endmodule

// File: rtl/gpx_bank_port.sv
module gpx_bank_port
    import gpx_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int ADDR_W    = 8,
    parameter bit SPLIT_OUT = 1'b1,
    parameter int PIN_BASE  = 'h12,
    parameter int SET_BASE  = 'h15,
    parameter int CLR_BASE  = 'h18,
    parameter int DIR_BASE  = 'h1B,
    parameter int RISE_BASE = 'h1E,
    parameter int FALL_BASE = 'h21,
    parameter int IEN_BASE  = 'h24,
    parameter int STAT_BASE = 'h30,
    parameter int EDGE_BASE = 'h34
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_we,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam int NB = num_banks(NUM_PINS);
    localparam int WW = NB * BANK_W;

    logic [WW-1:0] pad_wide;
    logic [WW-1:0] level, rose, fell;
    logic [WW-1:0] out_flat, dir_flat, stat_flat, edg_flat, evt_flat;
    bank_view_t    views [NB];
    bank_wr_t      wr    [NB];

    always_comb begin
        pad_wide = '0;
        pad_wide[NUM_PINS-1:0] = pad_in;
    end

    gpx_pin_sync #(.WIDTH(WW)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (pad_wide),
        .level  (level),
        .rose   (rose),
        .fell   (fell)
    );

    gpx_decode #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .SPLIT_OUT (SPLIT_OUT),
        .PIN_BASE  (PIN_BASE),
        .SET_BASE  (SET_BASE),
        .CLR_BASE  (CLR_BASE),
        .DIR_BASE  (DIR_BASE),
        .RISE_BASE (RISE_BASE),
        .FALL_BASE (FALL_BASE),
        .IEN_BASE  (IEN_BASE),
        .STAT_BASE (STAT_BASE),
        .EDGE_BASE (EDGE_BASE)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .views    (views),
        .wr       (wr),
        .rdata    (bus_rdata)
    );

    for (genvar k = 0; k < NB; k++) begin : g_bank
        byte_t evt_k;

        gpx_bank #(.VALID(valid_mask(NUM_PINS, k))) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr[k]),
            .wdata (bus_wdata),
            .level (level[k*BANK_W +: BANK_W]),
            .rose  (rose[k*BANK_W +: BANK_W]),
            .fell  (fell[k*BANK_W +: BANK_W]),
            .view  (views[k]),
            .evt   (evt_k)
        );

        assign out_flat[k*BANK_W +: BANK_W]  = views[k].out;
        assign dir_flat[k*BANK_W +: BANK_W]  = views[k].dir;
        assign stat_flat[k*BANK_W +: BANK_W] = views[k].stat;
        assign edg_flat[k*BANK_W +: BANK_W]  = views[k].edg;
        assign evt_flat[k*BANK_W +: BANK_W]  = evt_k;
    end

    gpx_irq_merge #(.NB(NB)) u_irq (
        .views (views),
        .irq   (irq)
    );

    assign pad_out = out_flat[NUM_PINS-1:0];
    assign pad_oe  = dir_flat[NUM_PINS-1:0];

endmodule

// File: rtl/gpx_bank_port_chk.sv
module gpx_bank_port_chk #(
    parameter int NUM_PINS  = 24,
    parameter int ADDR_W    = 8,
    parameter bit SPLIT_OUT = 1'b1,
    parameter int SET_BASE  = 'h15,
    parameter int CLR_BASE  = 'h18,
    localparam int WW       = ((NUM_PINS + 7) / 8) * 8,
    localparam int B0W      = (NUM_PINS < 8) ? NUM_PINS : 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_wdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq,
    input logic [WW-1:0]       stat_all,
    input logic [WW-1:0]       edg_all,
    input logic [WW-1:0]       evt_all
);

    // R3: set write drives the written ones high in bank 0
    assert_set_high_R3: assert property (@(posedge clk) disable iff (rst)
        (SPLIT_OUT && bus_we && (int'(bus_addr) == SET_BASE)) |=>
        ((pad_out[B0W-1:0] & $past(bus_wdata[B0W-1:0])) == $past(bus_wdata[B0W-1:0])));

    // R3: clear write drives the written ones low in bank 0
    assert_clr_low_R3: assert property (@(posedge clk) disable iff (rst)
        (SPLIT_OUT && bus_we && (int'(bus_addr) == CLR_BASE)) |=>
        ((pad_out[B0W-1:0] & $past(bus_wdata[B0W-1:0])) == '0));

    // R3: without a bus write the output latches hold
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(pad_out));

    // R5: without a bus write the directions hold
    assert_dir_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(pad_oe));

    // R7 and R12: every selected edge is recorded, even against a clear
    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_all != '0) |=> ((edg_all & $past(evt_all)) == $past(evt_all)));

    // R11: the interrupt needs some pending status bit
    assert_irq_pending_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_all != '0));

endmodule

bind gpx_bank_port gpx_bank_port_chk #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .SPLIT_OUT (SPLIT_OUT),
    .SET_BASE  (SET_BASE),
    .CLR_BASE  (CLR_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .stat_all  (stat_flat),
    .edg_all   (edg_flat),
    .evt_all   (evt_flat)
);

// File: tb/gpx_bank_port_bench.sv
`timescale 1ns/1ps
module gpx_bank_port_bench;

    localparam int A_PIN  = 'h12;
    localparam int A_SET  = 'h15;
    localparam int A_CLR  = 'h18;
    localparam int A_DIR  = 'h1B;
    localparam int A_RISE = 'h1E;
    localparam int A_FALL = 'h21;
    localparam int A_IEN  = 'h24;
    localparam int A_STAT = 'h30;
    localparam int A_EDGE = 'h34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // full-width split-output instance
    logic [7:0]  a_addr = '0, a_wdata = '0, a_rdata;
    logic        a_we = 1'b0, a_irq;
    logic [23:0] a_pad = '0, a_out, a_oe;

    // 12-pin combined-output instance
    logic [7:0]  c_addr = '0, c_wdata = '0, c_rdata;
    logic        c_we = 1'b0, c_irq;
    logic [11:0] c_pad = '0, c_out, c_oe;

    gpx_bank_port u_gpx_bank_port (
        .clk(clk), .rst(rst), .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_we(a_we),
        .bus_rdata(a_rdata), .pad_in(a_pad), .pad_out(a_out), .pad_oe(a_oe), .irq(a_irq)
    );

    gpx_bank_port #(.NUM_PINS(12), .SPLIT_OUT(1'b0)) u_gpx_bank_port_comb (
        .clk(clk), .rst(rst), .bus_addr(c_addr), .bus_wdata(c_wdata), .bus_we(c_we),
        .bus_rdata(c_rdata), .pad_in(c_pad), .pad_out(c_out), .pad_oe(c_oe), .irq(c_irq)
    );

    int checks = 0;
    int failures = 0;

    // bench model of the full-width instance
    logic [23:0] m_out = '0, m_dir = '0, m_rise = '0, m_fall = '0, m_ien = '0;
    logic [23:0] m_stat = '0, m_edg = '0, m_pad = '0;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_a(input int addr, input logic [7:0] d);
        a_addr = 8'(addr); a_wdata = d; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
    endtask

    task automatic rd_a(input int addr, output logic [7:0] d);
        a_addr = 8'(addr); a_we = 1'b0;
        #1 d = a_rdata;
        @(negedge clk);
    endtask

    task automatic wr_c(input int addr, input logic [7:0] d);
        c_addr = 8'(addr); c_wdata = d; c_we = 1'b1;
        @(negedge clk);
        c_we = 1'b0;
    endtask

    task automatic rd_c(input int addr, output logic [7:0] d);
        c_addr = 8'(addr); c_we = 1'b0;
        #1 d = c_rdata;
        @(negedge clk);
    endtask

    function automatic logic [7:0] bank_of(input logic [23:0] v, input int b);
        return v[b*8 +: 8];
    endfunction

    function automatic logic exp_irq();
        return |(m_stat & m_ien);
    endfunction

    task automatic drive_pads_a(input logic [23:0] nv);
        logic [23:0] ev;
        ev = (nv & ~m_pad & m_rise) | (~nv & m_pad & m_fall);
        m_edg  = m_edg | ev;
        m_stat = m_stat | (ev & ~m_dir);
        m_pad  = nv;
        a_pad  = nv;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_ports_a();
        check("R3/R5 pad_out", 32'(a_out), 32'(m_out));
        check("R5 pad_oe", 32'(a_oe), 32'(m_dir));
        check("R11 irq", 32'(a_irq), 32'(exp_irq()));
    endtask

    task automatic check_regs_a();
        logic [7:0] d;
        for (int b = 0; b < 3; b++) begin
            rd_a(A_PIN - b, d);  check("R6 input state", 32'(d), 32'(bank_of(m_pad, b)));
            rd_a(A_SET - b, d);  check("R2 set readback", 32'(d), 32'(bank_of(m_out, b)));
            rd_a(A_CLR - b, d);  check("R3 clr readback", 32'(d), 32'(bank_of(m_out, b)));
            rd_a(A_DIR - b, d);  check("R2 dir", 32'(d), 32'(bank_of(m_dir, b)));
            rd_a(A_RISE - b, d); check("R2 rise", 32'(d), 32'(bank_of(m_rise, b)));
            rd_a(A_FALL - b, d); check("R2 fall", 32'(d), 32'(bank_of(m_fall, b)));
            rd_a(A_IEN - b, d);  check("R2 ien", 32'(d), 32'(bank_of(m_ien, b)));
            rd_a(A_STAT + 2 - b, d); check("R8/R9 status", 32'(d), 32'(bank_of(m_stat, b)));
            rd_a(A_EDGE + 2 - b, d); check("R7/R9 edge", 32'(d), 32'(bank_of(m_edg, b)));
        end
    endtask

    task automatic rand_op();
        int op;
        int b;
        logic [7:0] d;
        op = $urandom_range(0, 11);
        b  = $urandom_range(0, 2);
        d  = 8'($urandom);
        case (op)
            0: begin wr_a(A_SET - b, d);  m_out[b*8 +: 8] = m_out[b*8 +: 8] | d;  end
            1: begin wr_a(A_CLR - b, d);  m_out[b*8 +: 8] = m_out[b*8 +: 8] & ~d; end
            2: begin wr_a(A_DIR - b, d);  m_dir[b*8 +: 8]  = d; end
            3: begin wr_a(A_RISE - b, d); m_rise[b*8 +: 8] = d; end
            4: begin wr_a(A_FALL - b, d); m_fall[b*8 +: 8] = d; end
            5: begin wr_a(A_IEN - b, d);  m_ien[b*8 +: 8]  = d; end
            6: begin wr_a(A_STAT + 2 - b, d); m_stat[b*8 +: 8] = m_stat[b*8 +: 8] & ~d; end
            7: begin wr_a(A_EDGE + 2 - b, d); m_edg[b*8 +: 8]  = m_edg[b*8 +: 8] & ~d;  end
            default: drive_pads_a(24'($urandom));
        endcase
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0017));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of ports and registers
        check("R1 pad_out", 32'(a_out), 32'h0);
        check("R1 pad_oe", 32'(a_oe), 32'h0);
        check("R1 irq", 32'(a_irq), 32'h0);
        check_regs_a();

        // R6: synchronizer latency, pad set before edge k, readable after k+1
        a_addr = 8'(A_PIN);
        a_pad = 24'h000001; m_pad = 24'h000001;
        @(negedge clk);                         // after edge k
        check("R6 not yet", 32'(a_rdata), 32'h0);
        @(negedge clk);                         // after edge k+1
        check("R6 visible", 32'(a_rdata), 32'h01);
        drive_pads_a(24'h000000);

        // R12: event and clear coincide on pin 0
        wr_a(A_RISE, 8'h01); m_rise[0] = 1'b1;
        wr_a(A_FALL, 8'h01); m_fall[0] = 1'b1;
        wr_a(A_IEN,  8'h01); m_ien[0]  = 1'b1;
        drive_pads_a(24'h000001);
        check("R11 irq on edge", 32'(a_irq), 32'h1);
        a_pad = 24'h000000;                     // before edge k
        @(negedge clk);
        @(negedge clk);                         // clear sampled at edge k+2
        a_addr = 8'(A_STAT + 2); a_wdata = 8'h01; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
        m_pad = 24'h000000;
        rd_a(A_STAT + 2, d);
        check("R12 status kept", 32'(d), 32'h01);
        // R10: clear with quiet pads
        wr_a(A_STAT + 2, 8'h01); m_stat[0] = 1'b0;
        rd_a(A_STAT + 2, d);
        check("R10 status cleared", 32'(d), 32'h00);
        check("R11 irq low", 32'(a_irq), 32'h0);
        // R12 on edge-detect: rising event with coincident clear
        a_pad = 24'h000001;
        @(negedge clk);
        @(negedge clk);
        a_addr = 8'(A_EDGE + 2); a_wdata = 8'h01; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
        m_pad = 24'h000001; m_stat[0] = 1'b1;
        rd_a(A_EDGE + 2, d);
        check("R12 edge kept", 32'(d), 32'h01);

        // R8: edge on an output pin sets edge-detect only
        wr_a(A_DIR - 2, 8'h80);  m_dir[23]  = 1'b1;
        wr_a(A_RISE - 2, 8'h80); m_rise[23] = 1'b1;
        drive_pads_a(24'h800001);
        rd_a(A_STAT, d);  check("R8 output pin no status", 32'(d), 32'h00);
        rd_a(A_EDGE, d);  check("R7 output pin edge", 32'(d), 32'h80);

        // random mix
        for (int i = 0; i < 300; i++) begin
            rand_op();
            check_ports_a();
            if (i % 10 == 9) check_regs_a();
        end

        // R13: unmapped address on the full-width instance
        rd_a('h00, d); check("R13 unmapped", 32'(d), 32'h00);

        // R4: combined output variant
        wr_c(A_SET, 8'hA5);
        check("R4 load", 32'(c_out), 32'h0A5);
        wr_c(A_SET, 8'h0F);
        check("R4 zeros clear", 32'(c_out), 32'h00F);
        wr_c(A_SET - 1, 8'hFF);
        check("R4 bank1 load", 32'(c_out), 32'hF0F);
        rd_c(A_SET - 1, d);
        check("R13 missing pins read 0", 32'(d), 32'h0F);
        wr_c(A_CLR, 8'hFF);
        check("R4 clear addr ignored", 32'(c_out), 32'hF0F);
        rd_c(A_CLR, d);
        check("R13 clear addr reads 0", 32'(d), 32'h00);

        // R9: two-bank burst order on the 12-pin instance
        wr_c(A_RISE - 1, 8'h02);
        wr_c(A_IEN - 1, 8'h02);
        c_pad = 12'h200;
        repeat (3) @(negedge clk);
        rd_c(A_STAT, d);     check("R9 top bank first", 32'(d), 32'h02);
        rd_c(A_STAT + 1, d); check("R9 bank0 second", 32'(d), 32'h00);
        rd_c(A_EDGE, d);     check("R9 edge top bank", 32'(d), 32'h02);
        check("R11 comb irq", 32'(c_irq), 32'h1);
        wr_c(A_STAT, 8'h02);
        check("R10 comb clear irq", 32'(c_irq), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule